// File: doc/BRIEF.md
# Direct-Mapped Write-Through Cache

This block is a small blocking cache placed between one requester and main memory. It holds eight lines of one 32-bit word each, indexed by address bits [4:2] and tagged with address bits [31:5]. Both sides use valid/ready handshakes: a request port and a response port toward the requester, and a request port and a response port toward memory. Type encoding on every port is 0 for read and 1 for write.

Reads that hit are answered from the local arrays. Reads that miss fetch the word from memory, fill the line and return the data. Every write goes to memory, and the requester gets its write response only once memory has acknowledged it. While a memory transaction is outstanding, the cache accepts no new request. A new request is admitted only when every resource it might need is free, even if this particular request would not need all of them.

Two parameters shape the timing and policy. `WRITE_ALLOC` chooses whether a write miss installs the line. `HIT_LAT` chooses a one-cycle or two-cycle read-hit latency. The two-cycle option places a one-entry buffer in the hit path and still accepts one hit per cycle.

Top module: `wt_dm_cache`

## Requirements
- R1: After reset every line is invalid, `cresp_valid` and `mreq_valid` are low, and `creq_ready` is high when `mreq_ready` and `cresp_ready` are high.
- R2: A read hits when the line selected by address bits [4:2] is valid and its stored tag equals address bits [31:5]. A read hit returns the stored word and issues no memory request.
- R3: A read miss issues one memory read (`mreq_wr`=0) with the full request address. When the memory response arrives, the line is filled and its data is returned. A later read of that address then hits.
- R4: Every accepted write produces one memory write (`mreq_wr`=1) with the request address and data. The write response (`cresp_wr`=1, data zero) appears only after the memory response has been accepted.
- R5: With `WRITE_ALLOC`=0, a write miss leaves tags, valid bits and data unchanged. A write hit under either policy replaces the stored word.
- R6: With `WRITE_ALLOC`=1, a write miss installs the line (valid, tag, data), so a following read of that address hits and returns the written word.
- R7: From the acceptance of a read miss or a write until its memory response is accepted, `creq_ready` stays low.
- R8: Acceptance requires a free memory request slot and a free hit-response path, even for requests that use neither. No more than `HIT_LAT` accepted requests are ever awaiting their response.
- R9: `mresp_ready` is high only when the response register is empty or is being emptied in the same cycle.
- R10: With `HIT_LAT`=1, a read hit's response is valid in the cycle after acceptance, and consecutive hits are accepted in consecutive cycles.
- R11: With `HIT_LAT`=2, a read hit's response is valid two cycles after acceptance, and consecutive hits are still accepted in consecutive cycles.
- R12: Each response carries the type, opaque and length fields of its request, and stays stable while `cresp_valid` is high and `cresp_ready` is low.
- R13: A fill into an index that holds a different tag replaces that tag, so the earlier address misses next time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| creq_valid | input | 1 | Requester request valid |
| creq_ready | output | 1 | Cache can accept the request |
| creq_wr | input | 1 | Request type, 1 = write, 0 = read |
| creq_opq | input | OPQ_W | Requester tag, echoed in the response |
| creq_len | input | LEN_W | Length field, echoed in the response |
| creq_addr | input | AW | Byte address |
| creq_data | input | DW | Write data |
| cresp_valid | output | 1 | Response valid |
| cresp_ready | input | 1 | Requester accepts the response |
| cresp_wr | output | 1 | Response type |
| cresp_opq | output | OPQ_W | Echoed requester tag |
| cresp_len | output | LEN_W | Echoed length |
| cresp_data | output | DW | Read data, zero for writes |
| mreq_valid | output | 1 | Memory request valid |
| mreq_ready | input | 1 | Memory accepts the request |
| mreq_wr | output | 1 | Memory request type |
| mreq_opq | output | OPQ_W | Tag of the originating request |
| mreq_len | output | LEN_W | Length of the originating request |
| mreq_addr | output | AW | Memory address |
| mreq_data | output | DW | Write data, zero for reads |
| mresp_valid | input | 1 | Memory response valid |
| mresp_ready | output | 1 | Cache accepts the memory response |
| mresp_data | input | DW | Read data from memory |

## Verification
A corrupted tag or valid bit shows up at the memory port within one request: a read that should hit produces an unexpected memory read, or a read that should miss produces none. A stale data word shows up as a mismatched `cresp_data` on the next read of that address. A stuck wait flag shows up as `creq_ready` held low forever, and a wait flag that clears too early shows up as a request accepted before its predecessor's memory response. An error in the hit buffer shows up either as a one-cycle shift in hit latency or as a gap between back-to-back hit acceptances.

// File: rtl/wt_dm_cache.sv
module wt_dm_cache #(
  parameter bit WRITE_ALLOC = 1'b0,
  parameter int HIT_LAT     = 1,
  parameter int IDX_W       = 3,
  parameter int AW          = 32,
  parameter int DW          = 32,
  parameter int OPQ_W       = 8,
  parameter int LEN_W       = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             creq_valid,
  output logic             creq_ready,
  input  logic             creq_wr,
  input  logic [OPQ_W-1:0] creq_opq,
  input  logic [LEN_W-1:0] creq_len,
  input  logic [AW-1:0]    creq_addr,
  input  logic [DW-1:0]    creq_data,
  output logic             cresp_valid,
  input  logic             cresp_ready,
  output logic             cresp_wr,
  output logic [OPQ_W-1:0] cresp_opq,
  output logic [LEN_W-1:0] cresp_len,
  output logic [DW-1:0]    cresp_data,
  output logic             mreq_valid,
  input  logic             mreq_ready,
  output logic             mreq_wr,
  output logic [OPQ_W-1:0] mreq_opq,
  output logic [LEN_W-1:0] mreq_len,
  output logic [AW-1:0]    mreq_addr,
  output logic [DW-1:0]    mreq_data,
  input  logic             mresp_valid,
  output logic             mresp_ready,
  input  logic [DW-1:0]    mresp_data
);
  localparam int NL = 1 << IDX_W;
  localparam int TW = AW - IDX_W - 2;

  logic [NL-1:0] vld_q;
  logic [TW-1:0] tag_q [NL];
  logic [DW-1:0] dat_q [NL];

  logic             wait_q;
  logic             pend_wr;
  logic [OPQ_W-1:0] pend_opq;
  logic [LEN_W-1:0] pend_len;
  logic [IDX_W-1:0] pend_idx;
  logic [TW-1:0]    pend_tag;

  logic             path_free, hs_go, hs_busy;
  logic [OPQ_W-1:0] hs_opq;
  logic [LEN_W-1:0] hs_len;
  logic [DW-1:0]    hs_data;

  wire [IDX_W-1:0] ridx = creq_addr[IDX_W+1:2];
  wire [TW-1:0]    rtag = creq_addr[AW-1:IDX_W+2];
  wire hit      = vld_q[ridx] && (tag_q[ridx] == rtag);
  wire rsp_free = !cresp_valid || cresp_ready;
  wire mq_free  = !mreq_valid || mreq_ready;

  assign creq_ready  = !wait_q && mq_free && path_free;
  assign mresp_ready = wait_q && rsp_free && !hs_busy;

  wire accept     = creq_valid && creq_ready;
  wire acc_hit    = accept && !creq_wr && hit;
  wire acc_mem    = accept && !acc_hit;
  wire acc_wr     = accept && creq_wr;
  wire mresp_fire = mresp_valid && mresp_ready;
  wire fill       = mresp_fire && !pend_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        vld_q <= '0;
    else if (fill)                     vld_q[pend_idx] <= 1'b1;
    else if (acc_wr && WRITE_ALLOC)    vld_q[ridx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (fill) begin
      tag_q[pend_idx] <= pend_tag;
      dat_q[pend_idx] <= mresp_data;
    end else if (acc_wr && (hit || WRITE_ALLOC)) begin
      tag_q[ridx] <= rtag;
      dat_q[ridx] <= creq_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          wait_q <= 1'b0;
    else if (acc_mem)    wait_q <= 1'b1;
    else if (mresp_fire) wait_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (acc_mem) begin
      pend_wr  <= creq_wr;
      pend_opq <= creq_opq;
      pend_len <= creq_len;
      pend_idx <= ridx;
      pend_tag <= rtag;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          mreq_valid <= 1'b0;
    else if (acc_mem)    mreq_valid <= 1'b1;
    else if (mreq_ready) mreq_valid <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (acc_mem) begin
      mreq_wr   <= creq_wr;
      mreq_opq  <= creq_opq;
      mreq_len  <= creq_len;
      mreq_addr <= creq_addr;
      mreq_data <= creq_wr ? creq_data : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cresp_valid <= 1'b0;
    else if (mresp_fire || hs_go) cresp_valid <= 1'b1;
    else if (cresp_ready)         cresp_valid <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (mresp_fire) begin
      cresp_wr   <= pend_wr;
      cresp_opq  <= pend_opq;
      cresp_len  <= pend_len;
      cresp_data <= pend_wr ? '0 : mresp_data;
    end else if (hs_go) begin
      cresp_wr   <= 1'b0;
      cresp_opq  <= hs_opq;
      cresp_len  <= hs_len;
      cresp_data <= hs_data;
    end
  end

  if (HIT_LAT == 2) begin : g_buf
    logic             pb_vld;
    logic [OPQ_W-1:0] pb_opq;
    logic [LEN_W-1:0] pb_len;
    logic [DW-1:0]    pb_data;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        pb_vld <= 1'b0;
      else if (acc_hit)  pb_vld <= 1'b1;
      else if (rsp_free) pb_vld <= 1'b0;
    end

    always_ff @(posedge clk) begin
      if (acc_hit) begin
        pb_opq  <= creq_opq;
        pb_len  <= creq_len;
        pb_data <= dat_q[ridx];
      end
    end

    assign path_free = !pb_vld || rsp_free;
    assign hs_go     = pb_vld && rsp_free;
    assign hs_busy   = pb_vld;
    assign hs_opq    = pb_opq;
    assign hs_len    = pb_len;
    assign hs_data   = pb_data;

    assert_hit_lat2_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_hit ##1 rsp_free) |=> (cresp_valid && !cresp_wr && cresp_opq == $past(creq_opq, 2)));
  end else begin : g_dir
    assign path_free = rsp_free;
    assign hs_go     = acc_hit;
    assign hs_busy   = 1'b0;
    assign hs_opq    = creq_opq;
    assign hs_len    = creq_len;
    assign hs_data   = dat_q[ridx];

    assert_hit_lat1_R10: assert property (@(posedge clk) disable iff (!rst_n)
      acc_hit |=> (cresp_valid && !cresp_wr && cresp_opq == $past(creq_opq)));
  end

  assert_no_accept_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wait_q |-> !creq_ready);

  assert_hit_no_mem_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_hit |=> !mreq_valid);

  assert_write_fwd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    acc_wr |=> (mreq_valid && mreq_wr && mreq_addr == $past(creq_addr) && mreq_data == $past(creq_data)));

  assert_mresp_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mresp_valid && mresp_ready) |-> (!cresp_valid || cresp_ready));

  assert_rsp_held_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (cresp_valid && !cresp_ready) |=> (cresp_valid && $stable(cresp_opq) && $stable(cresp_data)));

  if (!WRITE_ALLOC) begin : g_na
    assert_no_alloc_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_wr && !hit) |=> (vld_q == $past(vld_q)));
  end
endmodule

// File: tb/wt_dm_cache_tb_top.sv
module wt_dm_cache_tb_cfg #(
  parameter bit WA   = 1'b0,
  parameter int LAT  = 1,
  parameter int SEED = 1
) (
  input  logic clk,
  input  logic rst_n,
  output int   n_chk,
  output int   n_bad,
  output logic done
);
  logic        creq_valid, creq_ready, creq_wr;
  logic [7:0]  creq_opq;
  logic [1:0]  creq_len;
  logic [31:0] creq_addr, creq_data;
  logic        cresp_valid, cresp_ready, cresp_wr;
  logic [7:0]  cresp_opq;
  logic [1:0]  cresp_len;
  logic [31:0] cresp_data;
  logic        mreq_valid, mreq_ready, mreq_wr;
  logic [7:0]  mreq_opq;
  logic [1:0]  mreq_len;
  logic [31:0] mreq_addr, mreq_data;
  logic        mresp_valid, mresp_ready;
  logic [31:0] mresp_data;

  wt_dm_cache #(.WRITE_ALLOC(WA), .HIT_LAT(LAT)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .creq_valid(creq_valid), .creq_ready(creq_ready), .creq_wr(creq_wr),
    .creq_opq(creq_opq), .creq_len(creq_len), .creq_addr(creq_addr), .creq_data(creq_data),
    .cresp_valid(cresp_valid), .cresp_ready(cresp_ready), .cresp_wr(cresp_wr),
    .cresp_opq(cresp_opq), .cresp_len(cresp_len), .cresp_data(cresp_data),
    .mreq_valid(mreq_valid), .mreq_ready(mreq_ready), .mreq_wr(mreq_wr),
    .mreq_opq(mreq_opq), .mreq_len(mreq_len), .mreq_addr(mreq_addr), .mreq_data(mreq_data),
    .mresp_valid(mresp_valid), .mresp_ready(mresp_ready), .mresp_data(mresp_data)
  );

  logic [31:0] mem [64];
  bit          rv [8];
  logic [26:0] rt [8];

  bit          op_wr[$];
  int          op_w[$];
  logic [31:0] op_d[$];
  string       op_tag[$];
  int          op_cnt;

  bit          e_wr[$];
  logic [9:0]  e_meta[$];
  logic [31:0] e_dat[$];
  int          e_acc[$];
  bit          e_hit[$];
  string       e_tag[$];

  bit          m_wr[$];
  logic [31:0] m_addr[$];
  logic [31:0] m_dat[$];
  string       m_tag[$];

  int          r_due[$];
  logic [31:0] r_dat[$];
  int          acc_log[$];

  int    cyc;
  bit    rr_mode, bwait, seen_head, cur_v, cur_wr;
  int    cur_w;
  logic [31:0] cur_d;
  logic [7:0]  cur_opq;
  logic [1:0]  cur_len;
  string cur_tag;

  function automatic logic [31:0] waddr(int w);
    return 32'h0000_1000 | (32'(w) << 2);
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s cfg(wa=%0d,lat=%0d) %s: actual %0h expected %0h",
               tag, WA, LAT, what, act, exp);
    end
  endtask

  task automatic add_op(input bit wr, input int w, input logic [31:0] d, input string tag);
    op_wr.push_back(wr); op_w.push_back(w); op_d.push_back(d); op_tag.push_back(tag);
  endtask

  task automatic model_accept();
    logic [31:0] a;
    int idx;
    bit h;
    a   = waddr(cur_w);
    idx = cur_w % 8;
    h   = rv[idx] && rt[idx] == a[31:5];
    acc_log.push_back(cyc);
    e_wr.push_back(cur_wr); e_meta.push_back({cur_opq, cur_len});
    e_acc.push_back(cyc); e_tag.push_back(cur_tag);
    if (!cur_wr) begin
      e_dat.push_back(mem[cur_w]);
      e_hit.push_back(h);
      if (!h) begin
        m_wr.push_back(1'b0); m_addr.push_back(a); m_dat.push_back(32'h0); m_tag.push_back(cur_tag);
        rv[idx] = 1'b1; rt[idx] = a[31:5]; bwait = 1'b1;
      end
    end else begin
      e_dat.push_back(32'h0);
      e_hit.push_back(1'b0);
      m_wr.push_back(1'b1); m_addr.push_back(a); m_dat.push_back(cur_d); m_tag.push_back(cur_tag);
      if (!h && WA) begin rv[idx] = 1'b1; rt[idx] = a[31:5]; end
      bwait = 1'b1;
    end
  endtask

  task automatic step();
    @(negedge clk);
    cyc++;
    if (cresp_valid && !seen_head && e_dat.size() > 0) begin
      seen_head = 1'b1;
      if (rr_mode && e_hit[0])
        chk(cyc - e_acc[0] == LAT, (LAT == 1) ? "R10" : "R11", "hit latency", cyc - e_acc[0], LAT);
      if (e_wr[0])
        chk(m_addr.size() == 0 && r_due.size() == 0, "R4", "write response before memory ack",
            r_due.size(), 0);
    end
    if (!cur_v && op_w.size() > 0) begin
      cur_v = 1'b1; cur_wr = op_wr.pop_front(); cur_w = op_w.pop_front();
      cur_d = op_d.pop_front(); cur_tag = op_tag.pop_front();
      cur_opq = op_cnt[7:0]; cur_len = op_cnt[1:0]; op_cnt++;
    end
    creq_valid  = cur_v;
    creq_wr     = cur_wr;
    creq_addr   = waddr(cur_w);
    creq_data   = cur_d;
    creq_opq    = cur_opq;
    creq_len    = cur_len;
    cresp_ready = rr_mode || ($urandom % 4 != 0);
    mreq_ready  = rr_mode || ($urandom % 4 != 0);
    mresp_valid = r_due.size() > 0 && r_due[0] <= cyc;
    mresp_data  = (r_dat.size() > 0) ? r_dat[0] : 32'h0;
    #1;
    if (bwait) chk(!creq_ready, "R7", "ready while waiting", creq_ready, 0);
    if (LAT == 1 && cresp_valid && !cresp_ready)
      chk(!creq_ready, "R8", "ready with blocked response", creq_ready, 0);
    if (mresp_valid && mresp_ready)
      chk(!cresp_valid || cresp_ready, "R9", "memory response taken while response blocked", 1, 0);

    if (creq_valid && creq_ready) begin
      model_accept();
      cur_v = 1'b0;
    end
    if (mreq_valid && mreq_ready) begin
      if (m_addr.size() == 0) begin
        chk(1'b0, "R2", "unexpected memory request", mreq_addr, 0);
      end else begin
        chk(mreq_addr == m_addr[0], m_tag[0], "memory address", mreq_addr, m_addr[0]);
        chk({mreq_wr, mreq_data} == {m_wr[0], m_dat[0]}, m_tag[0], "memory type/data",
            {mreq_wr, mreq_data}, {m_wr[0], m_dat[0]});
        void'(m_wr.pop_front()); void'(m_addr.pop_front());
        void'(m_dat.pop_front()); void'(m_tag.pop_front());
      end
      if (mreq_wr) mem[mreq_addr[7:2]] = mreq_data;
      r_due.push_back(cyc + (rr_mode ? 2 : 1 + int'($urandom % 4)));
      r_dat.push_back(mreq_wr ? 32'h0 : mem[mreq_addr[7:2]]);
    end
    if (mresp_valid && mresp_ready) begin
      void'(r_due.pop_front()); void'(r_dat.pop_front());
      bwait = 1'b0;
    end
    if (cresp_valid && cresp_ready) begin
      if (e_dat.size() == 0) begin
        chk(1'b0, "R12", "unexpected response", cresp_opq, 0);
      end else begin
        chk(cresp_data == e_dat[0], e_tag[0], "response data", cresp_data, e_dat[0]);
        chk({cresp_wr, cresp_opq, cresp_len} == {e_wr[0], e_meta[0]}, "R12", "response fields",
            {cresp_wr, cresp_opq, cresp_len}, {e_wr[0], e_meta[0]});
        void'(e_wr.pop_front()); void'(e_meta.pop_front()); void'(e_dat.pop_front());
        void'(e_acc.pop_front()); void'(e_hit.pop_front()); void'(e_tag.pop_front());
      end
      seen_head = 1'b0;
    end
    if (e_dat.size() > LAT) chk(1'b0, "R8", "pending responses", e_dat.size(), LAT);
  endtask

  task automatic drain();
    while (op_w.size() > 0 || cur_v || e_dat.size() > 0 || m_addr.size() > 0 || r_due.size() > 0)
      step();
  endtask

  initial begin
    int k;
    n_chk = 0; n_bad = 0; done = 1'b0; cyc = 0; op_cnt = 1;
    rr_mode = 1'b1; bwait = 1'b0; seen_head = 1'b0; cur_v = 1'b0;
    cur_wr = 1'b0; cur_w = 0; cur_d = 32'h0; cur_opq = 8'h0; cur_len = 2'h0; cur_tag = "";
    creq_valid = 1'b0; creq_wr = 1'b0; creq_opq = 8'h0; creq_len = 2'h0;
    creq_addr = 32'h0; creq_data = 32'h0;
    cresp_ready = 1'b1; mreq_ready = 1'b1; mresp_valid = 1'b0; mresp_data = 32'h0;
    for (int i = 0; i < 64; i++) mem[i] = 32'h5A00_0000 + 32'(i * 32'h0101);
    for (int i = 0; i < 8; i++) begin rv[i] = 1'b0; rt[i] = '0; end
    void'($urandom(SEED));

    @(posedge rst_n);
    @(negedge clk);
    #1;
    chk(!cresp_valid, "R1", "response valid after reset", cresp_valid, 0);
    chk(!mreq_valid, "R1", "memory request valid after reset", mreq_valid, 0);
    chk(creq_ready, "R1", "ready after reset", creq_ready, 1);

    add_op(1'b0, 0, 32'h0, "R1");
    add_op(1'b0, 0, 32'h0, "R2");
    add_op(1'b1, 0, 32'hCAFE_0001, "R4");
    add_op(1'b0, 0, 32'h0, "R5");
    add_op(1'b1, 8, 32'hBEEF_0002, WA ? "R6" : "R5");
    add_op(1'b0, 8, 32'h0, WA ? "R6" : "R3");
    add_op(1'b0, 0, 32'h0, "R13");
    add_op(1'b0, 0, 32'h0, "R3");
    add_op(1'b0, 3, 32'h0, "R3");
    drain();

    k = acc_log.size();
    for (int i = 0; i < 4; i++) add_op(1'b0, 3, 32'h0, (LAT == 1) ? "R10" : "R11");
    drain();
    chk(acc_log[k+3] - acc_log[k] == 3, (LAT == 1) ? "R10" : "R11", "back-to-back hit cycles",
        acc_log[k+3] - acc_log[k], 3);

    rr_mode = 1'b0;
    for (int i = 0; i < 300; i++) begin
      bit wr;
      wr = ($urandom % 3 == 0);
      add_op(wr, int'($urandom % 16), $urandom, wr ? (WA ? "R6" : "R5") : "R3");
    end
    drain();
    rr_mode = 1'b1;
    step();
    chk(!cresp_valid && !mreq_valid, "R3", "idle at end", {cresp_valid, mreq_valid}, 0);
    done = 1'b1;
  end
endmodule

module wt_dm_cache_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  int   c0, b0, c1, b1;
  logic d0, d1;

  always #2 clk = ~clk;

  wt_dm_cache_tb_cfg #(.WA(1'b0), .LAT(1), .SEED(11)) u_na (
    .clk(clk), .rst_n(rst_n), .n_chk(c0), .n_bad(b0), .done(d0));
  wt_dm_cache_tb_cfg #(.WA(1'b1), .LAT(2), .SEED(23)) u_wa (
    .clk(clk), .rst_n(rst_n), .n_chk(c1), .n_bad(b1), .done(d1));

  initial begin
    int t;
    int total;
    int bad;
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t = 0;
    while (!(d0 === 1'b1 && d1 === 1'b1) && t < 150000) begin
      @(posedge clk);
      t++;
    end
    #10;
    total = c0 + c1;
    bad   = b0 + b1;
    if (!(d0 === 1'b1 && d1 === 1'b1)) begin
      total++;
      bad++;
      $display("FAIL watchdog R7: actual %0d cycles expected completion", t);
    end
    $display("%0d/%0d checks passed", total - bad, total);
    $finish;
  end
endmodule